// File: doc/BRIEF.md
# Shared SRAM Bridge with Prefetch

This block sits between host memory cycles and a byte-wide SRAM on a private bus. The SRAM holds up to 64 Kbytes. Every host access is one 16-bit word, and the host gives it as a word address. A host write does not wait for the SRAM. The block stores the write in a single holding register and finishes the host cycle at once. Later it copies the word into the SRAM as two byte writes. The block stalls the host, by holding the ready line low, only when a second write arrives while the holding register is still full.

Host reads are served from a one-word prefetch register that carries the word address it holds. A read whose address matches this tag completes with no wait. A read that misses holds ready low while two SRAM bytes are fetched. Once a read has completed and the host drops the read strobe, the block fetches the next higher word in the background, so that sequential reads hit. Every SRAM access first asks for the private bus and waits for the grant. Any traffic from another private-bus master clears the prefetch word.

Top module: `sram_bridge`

## Requirements
- R1: After reset, and with no access active, `host_ready` is 1, `bus_req` is 0, and neither `sram_we` nor `sram_oe` is active.
- R2: A host access is active only when `host_sel` is 1, `host_refresh` is 0, and `host_rd` or `host_wr` is 1. A write made while the holding register is empty completes with no wait cycle.
- R3: A write made while the holding register still holds an undrained word keeps `host_ready` low until that word has reached the SRAM.
- R4: A drain writes the low data byte at SRAM byte address {word, 0} and then the high byte at {word, 1}.
- R5: A read miss holds `host_ready` low while two bytes are read from the SRAM. With the grant held and the engine idle, the read sees exactly 3 wait cycles and then returns the stored word.
- R6: A read whose address matches the valid prefetch tag completes with no wait. After a read completes and its strobe drops, word address + 1 is prefetched.
- R7: SRAM strobes occur only in cycles where `bus_gnt` is 1. While the grant is low, a stalled access keeps `bus_req` at 1.
- R8: A one-cycle pulse on `priv_other` clears the prefetch word. The next read of the formerly prefetched address is a miss.
- R9: A host write to the word held in the prefetch register clears that word. A later read returns the newly written data.
- R10: With `host_refresh` at 1 or `host_sel` at 0, read and write strobes are ignored: `host_ready` stays 1, `bus_req` stays 0, and the SRAM is not changed.
- R11: A pending posted write wins the private bus over a pending background prefetch.
- R12: A read waits while a posted write is still pending, so it returns the newest data for its word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_sel | input | 1 | External decode says the cycle targets the SRAM window |
| host_refresh | input | 1 | Refresh cycle in progress; accesses are ignored while it is 1 |
| host_rd | input | 1 | Memory read strobe |
| host_wr | input | 1 | Memory write strobe |
| host_waddr | input | AW-1 | Host word address |
| host_wdata | input | 2*BW | Host write word |
| host_rdata | output | 2*BW | Read word, valid while ready is 1 on a read |
| host_ready | output | 1 | Low stalls the host cycle |
| bus_req | output | 1 | Request for the private bus |
| bus_gnt | input | 1 | Private bus granted |
| priv_other | input | 1 | Another master used the private bus |
| sram_addr | output | AW | SRAM byte address |
| sram_wdata | output | BW | SRAM write byte |
| sram_rdata | input | BW | SRAM read byte, combinational from sram_addr |
| sram_we | output | 1 | SRAM write strobe |
| sram_oe | output | 1 | SRAM read strobe |

## Verification
The bench reads a cold word and then the next word. This separates the miss path, with exactly three waits, from the hit that the background prefetch sets up. It pulses the foreign-traffic input, and also writes to the prefetched word, between those reads; in both cases the bench expects a miss and the new data. With the grant held low, it issues back-to-back writes and a write followed by a read of the same word. This shows whether the holding register stalls correctly and stays coherent. In one ordering a write and a prefetch are both waiting, and the first SRAM strobe after the grant returns shows which of them wins the bus. Refresh-qualified and unselected strobes must leave the SRAM and the bus request untouched.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  typedef enum logic [2:0] {
    ENG_IDLE  = 3'd0,
    ENG_WR_LO = 3'd1,
    ENG_WR_HI = 3'd2,
    ENG_RD_LO = 3'd3,
    ENG_RD_HI = 3'd4
  } eng_state_t;
endpackage

// File: rtl/sbr_hold.sv
// Single posted-write holding register.
module sbr_hold #(
  parameter int WA = 15,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          clear,
  input  logic [WA-1:0] load_addr,
  input  logic [DW-1:0] load_data,
  output logic          valid,
  output logic [WA-1:0] addr,
  output logic [DW-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) valid <= 1'b0;
    else if (load) valid <= 1'b1;
    else if (clear) valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      addr <= load_addr;
      data <= load_data;
    end
  end
endmodule

// File: rtl/sbr_prefetch.sv
// Tagged one-word prefetch register plus the pending look-ahead address.
module sbr_prefetch #(
  parameter int WA = 15,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          kill,
  input  logic          fill,
  input  logic [WA-1:0] fill_addr,
  input  logic [DW-1:0] fill_data,
  input  logic          arm,
  input  logic [WA-1:0] arm_addr,
  input  logic          launch,
  output logic          valid,
  output logic [WA-1:0] tag,
  output logic [DW-1:0] data,
  output logic          want,
  output logic [WA-1:0] next_addr
);
  always_ff @(posedge clk) begin
    if (rst) valid <= 1'b0;
    else if (kill) valid <= 1'b0;
    else if (fill) valid <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fill) begin
      tag  <= fill_addr;
      data <= fill_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) want <= 1'b0;
    else if (arm) want <= 1'b1;
    else if (launch) want <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (arm) next_addr <= arm_addr;
  end
endmodule

// File: rtl/sbr_engine.sv
// Private-bus engine: two byte cycles per word, advancing only while granted.
module sbr_engine
  import sbr_pkg::*;
#(
  parameter int WA = 15,
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            gnt,
  input  logic            want_drain,
  input  logic            want_fill,
  input  logic            want_ahead,
  input  logic [WA-1:0]   drain_addr,
  input  logic [2*BW-1:0] drain_data,
  input  logic [WA-1:0]   fill_addr,
  input  logic [WA-1:0]   ahead_addr,
  input  logic [BW-1:0]   mem_rdata,
  output logic [WA:0]     mem_addr,
  output logic [BW-1:0]   mem_wdata,
  output logic            mem_we,
  output logic            mem_oe,
  output eng_state_t      state_o,
  output logic            drain_start,
  output logic            drain_done,
  output logic            rd_start,
  output logic            fill_done,
  output logic [WA-1:0]   fill_tag,
  output logic [2*BW-1:0] fill_word
);
  eng_state_t      state;
  logic [WA-1:0]   cur_addr;
  logic [BW-1:0]   lo_q;
  logic            idle_g;
  logic            hi_phase;

  always_comb begin
    idle_g      = (state == ENG_IDLE) && gnt;
    drain_start = idle_g && want_drain;
    rd_start    = idle_g && !want_drain && (want_fill || want_ahead);
    hi_phase    = (state == ENG_WR_HI) || (state == ENG_RD_HI);
    mem_we      = gnt && ((state == ENG_WR_LO) || (state == ENG_WR_HI));
    mem_oe      = gnt && ((state == ENG_RD_LO) || (state == ENG_RD_HI));
    mem_addr    = {cur_addr, hi_phase};
    mem_wdata   = (state == ENG_WR_HI) ? drain_data[2*BW-1:BW] : drain_data[BW-1:0];
    drain_done  = gnt && (state == ENG_WR_HI);
    fill_done   = gnt && (state == ENG_RD_HI);
    fill_tag    = cur_addr;
    fill_word   = {mem_rdata, lo_q};
    state_o     = state;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ENG_IDLE;
    end else if (gnt) begin
      unique case (state)
        ENG_IDLE: begin
          if (drain_start) begin
            state    <= ENG_WR_LO;
            cur_addr <= drain_addr;
          end else if (rd_start) begin
            state    <= ENG_RD_LO;
            cur_addr <= want_fill ? fill_addr : ahead_addr;
          end
        end
        ENG_WR_LO: state <= ENG_WR_HI;
        ENG_WR_HI: state <= ENG_IDLE;
        ENG_RD_LO: begin
          lo_q  <= mem_rdata;
          state <= ENG_RD_HI;
        end
        ENG_RD_HI: state <= ENG_IDLE;
        default:   state <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sram_bridge.sv
// Host-side bridge to a byte-wide private SRAM with posted writes and read prefetch.
module sram_bridge
  import sbr_pkg::*;
#(
  parameter int AW = 16,
  parameter int BW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            host_sel,
  input  logic            host_refresh,
  input  logic            host_rd,
  input  logic            host_wr,
  input  logic [AW-2:0]   host_waddr,
  input  logic [2*BW-1:0] host_wdata,
  output logic [2*BW-1:0] host_rdata,
  output logic            host_ready,
  output logic            bus_req,
  input  logic            bus_gnt,
  input  logic            priv_other,
  output logic [AW-1:0]   sram_addr,
  output logic [BW-1:0]   sram_wdata,
  input  logic [BW-1:0]   sram_rdata,
  output logic            sram_we,
  output logic            sram_oe
);
  localparam int WA = AW - 1;
  localparam int DW = 2 * BW;

  logic          access, done_q, wr_cyc, rd_cyc, tag_eq, hit;
  logic          wr_take, rd_take, do_fill, do_ahead, eng_busy, kill;
  logic          hold_valid;
  logic [WA-1:0] hold_addr;
  logic [DW-1:0] hold_data;
  logic          pf_valid, pf_want;
  logic [WA-1:0] pf_tag, pf_next;
  logic [DW-1:0] pf_data;
  eng_state_t    eng_state;
  logic          drain_start, drain_done, rd_start, fill_done;
  logic [WA-1:0] fill_tag;
  logic [DW-1:0] fill_word;

  always_comb begin
    access   = host_sel && !host_refresh && (host_rd || host_wr);
    wr_cyc   = access && host_wr && !done_q;
    rd_cyc   = access && !host_wr && host_rd && !done_q;
    tag_eq   = pf_valid && (pf_tag == host_waddr);
    hit      = tag_eq && !hold_valid;
    wr_take  = wr_cyc && !hold_valid;
    rd_take  = rd_cyc && hit;
    do_fill  = rd_cyc && !tag_eq;
    do_ahead = pf_want && !access;
    eng_busy = (eng_state != ENG_IDLE);
    kill     = priv_other || drain_start || (wr_take && tag_eq);
  end

  assign host_ready = !access || done_q || wr_take || rd_take;
  assign bus_req    = hold_valid || do_fill || do_ahead || eng_busy;
  assign host_rdata = pf_data;

  // One acceptance per host cycle; cleared once the strobes drop.
  always_ff @(posedge clk) begin
    if (rst || !access) done_q <= 1'b0;
    else if (wr_take || rd_take) done_q <= 1'b1;
  end

  sbr_hold #(.WA(WA), .DW(DW)) u_hold (
    .clk(clk), .rst(rst), .load(wr_take), .clear(drain_done),
    .load_addr(host_waddr), .load_data(host_wdata),
    .valid(hold_valid), .addr(hold_addr), .data(hold_data)
  );

  sbr_prefetch #(.WA(WA), .DW(DW)) u_pf (
    .clk(clk), .rst(rst), .kill(kill),
    .fill(fill_done), .fill_addr(fill_tag), .fill_data(fill_word),
    .arm(rd_take), .arm_addr(host_waddr + 1'b1), .launch(rd_start),
    .valid(pf_valid), .tag(pf_tag), .data(pf_data),
    .want(pf_want), .next_addr(pf_next)
  );

  sbr_engine #(.WA(WA), .BW(BW)) u_eng (
    .clk(clk), .rst(rst), .gnt(bus_gnt),
    .want_drain(hold_valid), .want_fill(do_fill), .want_ahead(do_ahead),
    .drain_addr(hold_addr), .drain_data(hold_data),
    .fill_addr(host_waddr), .ahead_addr(pf_next),
    .mem_rdata(sram_rdata), .mem_addr(sram_addr), .mem_wdata(sram_wdata),
    .mem_we(sram_we), .mem_oe(sram_oe), .state_o(eng_state),
    .drain_start(drain_start), .drain_done(drain_done),
    .rd_start(rd_start), .fill_done(fill_done),
    .fill_tag(fill_tag), .fill_word(fill_word)
  );
endmodule

// File: rtl/sbr_checks.sv
module sbr_checks
  import sbr_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       access,
  input logic       host_rd,
  input logic       host_wr,
  input logic       host_ready,
  input logic       done_q,
  input logic       hold_valid,
  input logic       pf_valid,
  input logic       bus_gnt,
  input logic       sram_we,
  input logic       priv_other,
  input eng_state_t eng_state
);
  assert_we_grant_R7: assert property (@(posedge clk) disable iff (rst)
    sram_we |-> bus_gnt);

  assert_idle_ready_R10: assert property (@(posedge clk) disable iff (rst)
    !access |-> host_ready);

  assert_drain_first_R11: assert property (@(posedge clk) disable iff (rst)
    (eng_state == ENG_IDLE && hold_valid && bus_gnt) |=> (eng_state == ENG_WR_LO));

  assert_kill_R8: assert property (@(posedge clk) disable iff (rst)
    priv_other |=> !pf_valid);

  assert_read_from_word_R6: assert property (@(posedge clk) disable iff (rst)
    (access && host_rd && !host_wr && !done_q && host_ready) |-> (pf_valid && !hold_valid));

  assert_post_R2: assert property (@(posedge clk) disable iff (rst)
    (access && host_wr && !done_q && host_ready) |=> hold_valid);
endmodule

bind sram_bridge sbr_checks u_checks (
  .clk(clk), .rst(rst), .access(access), .host_rd(host_rd), .host_wr(host_wr),
  .host_ready(host_ready), .done_q(done_q), .hold_valid(hold_valid),
  .pf_valid(pf_valid), .bus_gnt(bus_gnt), .sram_we(sram_we),
  .priv_other(priv_other), .eng_state(eng_state)
);

// File: tb/sram_bridge_test.sv
`timescale 1ns/1ps
module sram_bridge_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_sel = 1'b0, host_refresh = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
  logic [14:0] host_waddr = '0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        host_ready, bus_req;
  logic        bus_gnt = 1'b1, priv_other = 1'b0;
  logic [15:0] sram_addr;
  logic [7:0]  sram_wdata, sram_rdata;
  logic        sram_we, sram_oe;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [7:0]  mem [0:255];
  logic [15:0] ref_mem [0:127];
  bit          track = 0;
  bit          first_we = 0;

  always #4 clk = ~clk;

  sram_bridge uut (
    .clk(clk), .rst(rst), .host_sel(host_sel), .host_refresh(host_refresh),
    .host_rd(host_rd), .host_wr(host_wr), .host_waddr(host_waddr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_ready(host_ready),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .priv_other(priv_other),
    .sram_addr(sram_addr), .sram_wdata(sram_wdata), .sram_rdata(sram_rdata),
    .sram_we(sram_we), .sram_oe(sram_oe)
  );

  // Byte-wide SRAM model
  assign sram_rdata = mem[sram_addr[7:0]];
  always @(posedge clk) if (sram_we) mem[sram_addr[7:0]] <= sram_wdata;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Per-clock comparison against the behavioural model
  always @(posedge clk) begin
    if (!rst) begin
      if (sram_we || sram_oe) chk(bus_gnt, "R7 strobe without grant", bus_gnt, 1);
      if (track && (sram_we || sram_oe)) begin
        first_we = sram_we;
        track = 0;
      end
      if (host_sel && !host_refresh && host_rd && !host_wr && host_ready)
        chk(host_rdata == ref_mem[host_waddr[6:0]], "R5/R6 read data",
            host_rdata, ref_mem[host_waddr[6:0]]);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog expired actual %0d expected %0d", cyc, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic do_write(input logic [14:0] w, input logic [15:0] d, output int waits);
    bit got = 0;
    @(negedge clk);
    host_sel = 1; host_wr = 1; host_waddr = w; host_wdata = d; waits = 0;
    for (int i = 0; i < 300; i++) begin
      #2;
      if (host_ready) begin got = 1; break; end
      waits++;
      @(negedge clk);
    end
    if (!got) chk(0, "R3 write never completed", waits, 0);
    @(posedge clk);
    ref_mem[w[6:0]] = d;
    @(negedge clk);
    host_sel = 0; host_wr = 0;
  endtask

  task automatic do_read(input logic [14:0] w, output logic [15:0] d, output int waits);
    bit got = 0;
    @(negedge clk);
    host_sel = 1; host_rd = 1; host_waddr = w; waits = 0; d = '0;
    for (int i = 0; i < 300; i++) begin
      #2;
      if (host_ready) begin got = 1; d = host_rdata; break; end
      waits++;
      @(negedge clk);
    end
    if (!got) chk(0, "R5 read never completed", waits, 0);
    @(posedge clk);
    @(negedge clk);
    host_sel = 0; host_rd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int w;
    logic [15:0] d;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    for (int i = 0; i < 128; i++) ref_mem[i] = {mem[2*i+1], mem[2*i]};
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    #2;
    // R1: idle outputs after reset
    chk(host_ready == 1, "R1 ready after reset", host_ready, 1);
    chk(bus_req == 0, "R1 bus_req after reset", bus_req, 0);
    chk(!sram_we && !sram_oe, "R1 strobes after reset", {sram_we, sram_oe}, 0);

    // R5: cold read miss, exact wait count
    do_read(15'd5, d, w);
    chk(w == 3, "R5 miss waits", w, 3);
    chk(d == ref_mem[5], "R5 miss data", d, ref_mem[5]);

    // R6: sequential read hits the prefetched next word
    idle(6);
    do_read(15'd6, d, w);
    chk(w == 0, "R6 hit waits", w, 0);
    chk(d == ref_mem[6], "R6 hit data", d, ref_mem[6]);

    // R8: foreign private-bus traffic clears the prefetch
    idle(6);
    @(negedge clk); priv_other = 1;
    @(negedge clk); priv_other = 0;
    do_read(15'd7, d, w);
    chk(w == 3, "R8 miss after invalidate", w, 3);
    chk(d == ref_mem[7], "R8 data", d, ref_mem[7]);

    // R2, R4: posted write with empty holding register, byte order in SRAM
    idle(6);
    do_write(15'd20, 16'hBEEF, w);
    chk(w == 0, "R2 posted write waits", w, 0);
    idle(6);
    chk(mem[40] == 8'hEF, "R4 low byte at even address", mem[40], 8'hEF);
    chk(mem[41] == 8'hBE, "R4 high byte at odd address", mem[41], 8'hBE);

    // R9: write to the prefetched word clears it
    do_read(15'd30, d, w);
    idle(6);
    do_write(15'd31, 16'h1234, w);
    do_read(15'd31, d, w);
    chk(w > 0, "R9 read after write to tag misses", w, 1);
    chk(d == 16'h1234, "R9 new data", d, 16'h1234);

    // R3, R7: second write stalls while grant low and hold full
    idle(6);
    @(negedge clk); bus_gnt = 0;
    do_write(15'd40, 16'hA1A2, w);
    chk(w == 0, "R2 first write with grant low", w, 0);
    fork
      do_write(15'd41, 16'hB1B2, w);
      begin
        repeat (6) @(negedge clk);
        #2;
        chk(bus_req == 1, "R7 request while stalled", bus_req, 1);
        bus_gnt = 1;
      end
    join
    chk(w >= 6, "R3 write stalled until drain", w, 6);
    idle(8);
    chk({mem[81], mem[80]} == 16'hA1A2, "R4 drained first word", {mem[81], mem[80]}, 16'hA1A2);
    chk({mem[83], mem[82]} == 16'hB1B2, "R4 drained second word", {mem[83], mem[82]}, 16'hB1B2);

    // R12: read of a word still in the holding register waits for the drain
    @(negedge clk); bus_gnt = 0;
    do_write(15'd50, 16'h7777, w);
    fork
      do_read(15'd50, d, w);
      begin
        repeat (4) @(negedge clk);
        bus_gnt = 1;
      end
    join
    chk(w >= 4, "R12 read waits on pending write", w, 4);
    chk(d == 16'h7777, "R12 read returns posted data", d, 16'h7777);

    // R11: pending write beats pending prefetch
    idle(6);
    do_read(15'd60, d, w);
    bus_gnt = 0;
    do_write(15'd70, 16'hCAFE, w);
    track = 1;
    @(negedge clk); bus_gnt = 1;
    idle(8);
    chk(first_we == 1, "R11 write wins bus over prefetch", first_we, 1);
    do_read(15'd70, d, w);
    chk(d == 16'hCAFE, "R11 written data readable", d, 16'hCAFE);

    // R10: refresh-qualified or unselected strobes are ignored
    idle(6);
    @(negedge clk);
    host_sel = 1; host_refresh = 1; host_wr = 1; host_waddr = 15'd20; host_wdata = 16'h0000;
    for (int i = 0; i < 3; i++) begin
      #2;
      chk(host_ready && !bus_req, "R10 refresh ignored", {host_ready, bus_req}, 2);
      @(negedge clk);
    end
    host_refresh = 0; host_sel = 0;
    for (int i = 0; i < 3; i++) begin
      #2;
      chk(host_ready && !bus_req, "R10 unselected ignored", {host_ready, bus_req}, 2);
      @(negedge clk);
    end
    host_wr = 0;
    idle(4);
    chk({mem[41], mem[40]} == 16'hBEEF, "R10 SRAM unchanged", {mem[41], mem[40]}, 16'hBEEF);
    do_read(15'd20, d, w);
    chk(d == 16'hBEEF, "R10 read after ignored write", d, 16'hBEEF);

    idle(4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule